// File: doc/BRIEF.md
# IF Sample Limiter and Decimator

This block sits directly behind a high-speed converter that digitises a 10.7 MHz intermediate frequency carrying an FM signal. The converter delivers 13-bit offset-binary codes with a ready pulse. The block latches a code only on that pulse and flips the top bit to turn it into two's complement. Each sample then passes through a hysteresis limiter, which behaves like a comparator with a dead band and throws away the amplitude. The amplitude carries no information in FM, and the dead band keeps converter noise from toggling the output.

The limiter drives one of two levels, just under plus half scale or exactly minus half scale, so later filters have headroom and cannot overflow. The limited value is sign-extended to 16 bits. Only every eighth accepted sample is passed on, which takes a 66.5 MHz stream down to 8.3125 MHz.

The input side has no back-pressure because the converter free-runs. The output side is a valid strobe with no ready: a consumer must take each sample in the cycle its strobe is high. The output value stays the same until the next strobe.

Top module: `if_limit_decim`

## Requirements
- R1: A code on `adc_code` is accepted only in a cycle where `adc_rdy` is high. Codes present while `adc_rdy` is low neither move the limiter nor count toward decimation.
- R2: The accepted code is offset binary and is read as two's complement with its bit 12 inverted. Code 0x0000 is -4096, code 0x1000 is 0 and code 0x1FFF is +4095.
- R3: A converted sample above +120 sets the limiter to the positive level, +2047. A sample below -120 sets it to the negative level, -2048.
- R4: A converted sample from -120 to +120 inclusive leaves the limiter level unchanged.
- R5: The 16-bit output is the 13-bit limiter level sign-extended, so it is always 16'h07FF or 16'hF800 when the strobe is high.
- R6: `if_valid` is high for exactly one clock for every eighth accepted sample and is low otherwise.
- R7: `if_sample` changes only together with a high `if_valid` and holds its value between strobes.
- R8: After reset `if_valid` is 0 and `if_sample` is 0. The limiter starts at the positive level and the decimation count starts at zero, so the eighth accepted in-band sample yields 16'h07FF.
- R9: The strobe for an eighth sample is visible after the third rising edge, counting the edge that captures that sample as the first. It reflects the limiter level after that sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter sample clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_code | input | 13 | Offset-binary code from the converter |
| adc_rdy | input | 1 | Converter data-ready; qualifies `adc_code` |
| if_sample | output | 16 | Limited, sign-extended, decimated sample |
| if_valid | output | 1 | One-clock strobe marking a new `if_sample` |

## Verification
The bench drives samples exactly at the band edges: ±120 must hold the level and ±121 must switch it. A limiter built with inclusive comparisons, or with no hysteresis at all, would flip the output there. It toggles `adc_code` to full-scale values while `adc_rdy` is low, partway through a decimation group. A design that latches without the qualifier would change the level or fire the strobe early. It streams samples back to back to pin the strobe to the eighth sample at a fixed latency. It also feeds the extreme codes 0x0000 and 0x1FFF, which catch a missing bit-12 inversion and a truncated sign extension.

// File: rtl/if_limit_pkg.sv
package if_limit_pkg;
  // Limiter state: which of the two output levels is driven.
  typedef enum logic {
    LIM_NEG = 1'b0,
    LIM_POS = 1'b1
  } lim_state_e;
endpackage

// File: rtl/ifl_capture.sv
// Latches a converter code on data-ready and converts it to two's complement.
module ifl_capture #(
  parameter int DW = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DW-1:0]        code_in,
  input  logic                 code_rdy,
  output logic signed [DW-1:0] smp_q,
  output logic                 smp_v
);
  logic signed [DW-1:0] smp_d;

  // Offset binary to two's complement: flip the top bit only.
  always_comb begin
    smp_d = {~code_in[DW-1], code_in[DW-2:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q <= '0;
      smp_v <= 1'b0;
    end else begin
      smp_v <= code_rdy;
      if (code_rdy) smp_q <= smp_d;
    end
  end
endmodule

// File: rtl/ifl_limiter.sv
// Comparator with a symmetric dead band; drives one of two half-scale levels.
module ifl_limiter
  import if_limit_pkg::*;
#(
  parameter int DW   = 13,
  parameter int HYST = 120
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] smp,
  input  logic                 smp_v,
  output lim_state_e           state_q,
  output logic signed [DW-1:0] lvl,
  output logic                 lvl_v
);
  localparam logic signed [DW-1:0] HI_T  = DW'(HYST);
  localparam logic signed [DW-1:0] LO_T  = -HI_T;
  localparam logic signed [DW-1:0] L_POS = DW'((1 << (DW - 2)) - 1);
  localparam logic signed [DW-1:0] L_NEG = -(L_POS) - DW'(1);

  lim_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (smp_v) begin
      if (smp > HI_T)      state_d = LIM_POS;
      else if (smp < LO_T) state_d = LIM_NEG;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LIM_POS;
      lvl_v   <= 1'b0;
    end else begin
      state_q <= state_d;
      lvl_v   <= smp_v;
    end
  end

  always_comb begin
    lvl = (state_q == LIM_POS) ? L_POS : L_NEG;
  end
endmodule

// File: rtl/ifl_decimator.sv
// Keeps one sample in DECIM, sign-extends it and registers it with a strobe.
module ifl_decimator #(
  parameter int DW    = 13,
  parameter int OW    = 16,
  parameter int DECIM = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] lvl,
  input  logic                 lvl_v,
  output logic [OW-1:0]        out_data,
  output logic                 out_valid
);
  localparam int CW = (DECIM > 1) ? $clog2(DECIM) : 1;

  logic          take;
  logic [OW-1:0] ext;

  always_comb begin
    ext = {{(OW - DW){lvl[DW-1]}}, lvl};
  end

  generate
    if (DECIM == 1) begin : g_pass
      always_comb take = lvl_v;
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (lvl_v) begin
          cnt_q <= (cnt_q == CW'(DECIM - 1)) ? '0 : cnt_q + CW'(1);
        end
      end
      always_comb take = lvl_v && (cnt_q == CW'(DECIM - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= take;
      if (take) out_data <= ext;
    end
  end
endmodule

// File: rtl/if_limit_decim.sv
module if_limit_decim
  import if_limit_pkg::*;
#(
  parameter int DW    = 13,
  parameter int OW    = 16,
  parameter int HYST  = 120,
  parameter int DECIM = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [12:0]   adc_code,
  input  logic          adc_rdy,
  output logic [15:0]   if_sample,
  output logic          if_valid
);
  logic signed [DW-1:0] cap_smp;
  logic                 cap_v;
  lim_state_e           lim_state;
  logic signed [DW-1:0] lim_lvl;
  logic                 lim_v;
  logic                 lim_pos;

  ifl_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .code_in(adc_code), .code_rdy(adc_rdy),
    .smp_q(cap_smp), .smp_v(cap_v)
  );

  ifl_limiter #(.DW(DW), .HYST(HYST)) u_lim (
    .clk(clk), .rst(rst), .smp(cap_smp), .smp_v(cap_v),
    .state_q(lim_state), .lvl(lim_lvl), .lvl_v(lim_v)
  );

  assign lim_pos = (lim_state == LIM_POS);

  ifl_decimator #(.DW(DW), .OW(OW), .DECIM(DECIM)) u_dec (
    .clk(clk), .rst(rst), .lvl(lim_lvl), .lvl_v(lim_v),
    .out_data(if_sample), .out_valid(if_valid)
  );
endmodule

// File: rtl/ifl_checker.sv
module ifl_checker #(
  parameter int DW   = 13,
  parameter int HYST = 120
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 adc_rdy,
  input logic signed [DW-1:0] cap_smp,
  input logic                 cap_v,
  input logic                 lim_pos,
  input logic [15:0]          if_sample,
  input logic                 if_valid
);
  localparam logic signed [DW-1:0] HI_T = DW'(HYST);
  localparam logic signed [DW-1:0] LO_T = -HI_T;

  p_latch_r1: assert property (@(posedge clk) disable iff (rst)
    !adc_rdy |=> $stable(cap_smp));
  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    adc_rdy |=> cap_v);
  p_up_r3: assert property (@(posedge clk) disable iff (rst)
    (cap_v && (cap_smp > HI_T)) |=> lim_pos);
  p_down_r3: assert property (@(posedge clk) disable iff (rst)
    (cap_v && (cap_smp < LO_T)) |=> !lim_pos);
  p_band_r4: assert property (@(posedge clk) disable iff (rst)
    (!cap_v || ((cap_smp <= HI_T) && (cap_smp >= LO_T))) |=> $stable(lim_pos));
  p_levels_r5: assert property (@(posedge clk) disable iff (rst)
    if_valid |-> ((if_sample == 16'h07FF) || (if_sample == 16'hF800)));
  p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    if_valid |=> !if_valid);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !if_valid |-> $stable(if_sample));
endmodule

bind if_limit_decim ifl_checker #(.DW(DW), .HYST(HYST)) u_chk (
  .clk(clk), .rst(rst), .adc_rdy(adc_rdy), .cap_smp(cap_smp),
  .cap_v(cap_v), .lim_pos(lim_pos), .if_sample(if_sample),
  .if_valid(if_valid)
);

// File: tb/tb_if_limit_decim.sv
module tb_if_limit_decim;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] adc_code = '0;
  logic        adc_rdy = 1'b0;
  logic [15:0] if_sample;
  logic        if_valid;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference state built from the requirements.
  bit          m_pos = 1'b1;
  int          m_cnt = 0;
  logic [15:0] m_out = 16'h0000;

  always #10 clk = ~clk;

  if_limit_decim dut (
    .clk(clk), .rst(rst), .adc_code(adc_code), .adc_rdy(adc_rdy),
    .if_sample(if_sample), .if_valid(if_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] enc(input int s);
    return 13'((s + 4096) & 13'h1FFF);
  endfunction

  // Update the model for one accepted sample; returns whether a strobe is due.
  function automatic bit model(input int s);
    if (s > 120) m_pos = 1'b1;
    else if (s < -120) m_pos = 1'b0;
    m_cnt++;
    if (m_cnt == 8) begin
      m_cnt = 0;
      m_out = m_pos ? 16'h07FF : 16'hF800;
      return 1'b1;
    end
    return 1'b0;
  endfunction

  // One isolated sample, then check valid/data three edges after capture (R9).
  task automatic push(input int s, input string tag);
    bit strobe;
    @(negedge clk);
    adc_code = enc(s);
    adc_rdy  = 1'b1;
    strobe   = model(s);
    @(negedge clk);
    adc_rdy  = 1'b0;
    @(negedge clk);
    chk(if_valid == 1'b0, {tag, " R9 early"}, int'(if_valid), 0);
    @(negedge clk);
    chk(if_valid == strobe, {tag, " R6 strobe"}, int'(if_valid), int'(strobe));
    chk(if_sample == m_out, {tag, " R7 data"}, int'(if_sample), int'(m_out));
  endtask

  task automatic t_reset;
    chk(if_valid == 1'b0, "R8 valid after reset", int'(if_valid), 0);
    chk(if_sample == 16'h0000, "R8 data after reset", int'(if_sample), 0);
    for (int i = 0; i < 8; i++) push((i % 2 == 0) ? 100 : -100, "R8 start positive");
    chk(if_sample == 16'h07FF, "R8 first group level", int'(if_sample), 16'h07FF);
  endtask

  task automatic t_switch;
    for (int i = 0; i < 8; i++) push(-121, "R3 down");
    chk(if_sample == 16'hF800, "R3 R5 negative level", int'(if_sample), 16'hF800);
    for (int i = 0; i < 8; i++) push(121, "R3 up");
    chk(if_sample == 16'h07FF, "R3 R5 positive level", int'(if_sample), 16'h07FF);
    // Extreme codes: 0x0000 is -4096, 0x1FFF is +4095, 0x1000 is 0.
    for (int i = 0; i < 7; i++) push(0, "R2 mid code");
    push(-4096, "R2 code 0000");
    chk(if_sample == 16'hF800, "R2 code 0000 negative", int'(if_sample), 16'hF800);
    for (int i = 0; i < 7; i++) push(0, "R2 mid code hold");
    push(4095, "R2 code 1FFF");
    chk(if_sample == 16'h07FF, "R2 code 1FFF positive", int'(if_sample), 16'h07FF);
  endtask

  task automatic t_band;
    for (int i = 0; i < 7; i++) push(-500, "R4 set neg");
    push(-500, "R4 set neg");
    for (int i = 0; i < 7; i++) push((i % 2 == 0) ? 120 : 0, "R4 band hi");
    push(120, "R4 edge +120");
    chk(if_sample == 16'hF800, "R4 +120 holds negative", int'(if_sample), 16'hF800);
    for (int i = 0; i < 7; i++) push(900, "R4 set pos");
    push(-120, "R4 edge -120");
    chk(if_sample == 16'h07FF, "R4 -120 holds positive", int'(if_sample), 16'h07FF);
  endtask

  task automatic t_ignore;
    for (int i = 0; i < 7; i++) push(300, "R1 group");
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      adc_rdy  = 1'b0;
      adc_code = (i % 2 == 0) ? 13'h0000 : 13'h1FFF;
      chk(if_valid == 1'b0, "R1 no strobe while not ready", int'(if_valid), 0);
    end
    push(0, "R1 eighth after idle");
    chk(if_sample == 16'h07FF, "R1 level untouched", int'(if_sample), 16'h07FF);
  endtask

  task automatic t_stream;
    int pulses = 0;
    for (int k = 0; k < 22; k++) begin
      @(negedge clk);
      if (if_valid) begin
        pulses++;
        chk((k == 10) || (k == 18), "R9 stream strobe cycle", k, 10);
        chk(if_sample == 16'hF800, "R6 stream level", int'(if_sample), 16'hF800);
      end
      if (k < 16) begin
        adc_code = enc(-700);
        adc_rdy  = 1'b1;
      end else begin
        adc_rdy = 1'b0;
      end
    end
    chk(pulses == 2, "R6 two strobes per 16 samples", pulses, 2);
    m_pos = 1'b0;
    m_out = 16'hF800;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_switch;
    t_band;
    t_ignore;
    t_stream;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule